// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block is a half-duplex serial transmitter that acts as clock master. It produces a shift clock from an internal divider and sends words least significant bit first on a data line. The host loads a word into a one-word holding register with a write strobe. The word then moves into a shift register when that register is free. Because of this, a new word can be queued while the previous one is still being shifted, and consecutive words go out with no gap in the clock.

The host controls the block with level inputs: a port enable, a master-clock enable, a transmit enable, a continuous-receive enable and a one-shot single-receive request. It also sets a 9-bit mode and supplies the value of the ninth bit. Receiving is represented only by its enables and by a completion pulse from an external receive stub. A receive enable stops the current transmission without resetting the transmitter. The clock and data outputs each have their own output enable, so they can be tri-stated outside the block.

Top module: `sync_master_tx`

## Requirements
- R1: After reset, `hold_empty` and `shift_empty` are 1, `sclk_o` is 0, and both `sclk_oe` and `sdat_oe` are 0.
- R2: A held word moves to the shift register only at a divider tick while the shift register is free. A word queued during shifting is transferred at the tick of the last falling clock edge, so the clock runs without a break across words.
- R3: `hold_empty` drops to 0 at the clock edge that samples `wr_stb`, and it rises only when a held word is transferred. A write in the same cycle as a transfer leaves it at 0.
- R4: `shift_empty` falls to 0 on a transfer. It rises at the falling clock edge that ends a word's last bit if no word is held, and it rises at once on any abort.
- R5: Words are sent LSB first, 8 bits per word. With `nine_mode`=1, a ninth bit follows bit 7. Each bit changes on a rising `sclk_o` edge and is stable at the following falling edge. The clock rests low between words.
- R6: With transmit enabled and nothing held, the clock does not toggle. A word written while transmit is disabled waits in the holding register and is sent once `tx_en` is set.
- R7: Each high and low phase of `sclk_o` lasts `divisor`+1 clock cycles. The divider is held in reset while `port_en` is 0 or while `tx_en`, `rx_cont_en` and the single-receive flag are all 0.
- R8: Clearing `tx_en` or `port_en` during a word sets both output enables to 0 in the same cycle. The word is dropped and `shift_empty` becomes 1, but a held word stays held. It is sent after `tx_en` is set again.
- R9: Setting `rx_cont_en` during a word drops that word and sets `sdat_oe` to 0. `sclk_oe` stays 1 and the clock keeps toggling while `master_en`=1. The held word and `hold_empty` are kept, and the held word is sent once the receive enable clears.
- R10: A pulse on `rx_single_req` sets `rx_single_busy`, which blocks transmission as in R9. `rx_word_done` clears it at the next edge, and `sdat_oe` returns to 1 at once if `tx_en` is still 1.
- R11: The ninth bit is taken from `bit9` at the moment of transfer, not at the moment of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| master_en | input | 1 | Block drives the shift clock |
| tx_en | input | 1 | Transmit enable |
| rx_cont_en | input | 1 | Continuous receive enable (overrides transmit) |
| rx_single_req | input | 1 | One-cycle pulse that requests a single-word receive |
| rx_word_done | input | 1 | Receive stub: single word complete |
| nine_mode | input | 1 | 9-bit word mode |
| bit9 | input | 1 | Ninth data bit |
| divisor | input | DIV_W | Half-period divisor; half period is divisor+1 cycles |
| wr_stb | input | 1 | Holding-register write strobe |
| wr_word | input | DATA_W | Word to transmit |
| hold_empty | output | 1 | Holding register empty |
| shift_empty | output | 1 | Shift register empty |
| rx_single_busy | output | 1 | Single-word receive in progress |
| sclk_o | output | 1 | Shift clock value |
| sclk_oe | output | 1 | Shift clock output enable |
| sdat_o | output | 1 | Serial data value |
| sdat_oe | output | 1 | Serial data output enable |

## Verification
The output enables are combinational from the control inputs, so they are checked in the same cycle the control changes. The bench drives inputs on the falling clock edge and samples at the next falling edge. The flags and the single-receive state are registered, so they are due at the first rising edge after the stimulus. Serial bits are captured at each falling `sclk_o` edge, but only while the shift register held data just before that edge. Every clock phase is measured in system cycles against `divisor`+1.

// File: rtl/smt_pkg.sv
package smt_pkg;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } smt_lvl_e;

  // Number of serial bits in a word for the chosen mode.
  function automatic int unsigned smt_frame_bits(input logic nine, input int unsigned dw);
    return nine ? dw + 1 : dw;
  endfunction

endpackage

// File: rtl/smt_baud.sv
module smt_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == divisor);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/smt_shifter.sv
module smt_shifter
  import smt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_hold,
  input  logic              tx_clear,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_word,
  input  logic              nine_mode,
  input  logic              bit9,
  output logic              load,
  output logic              sclk,
  output logic              sdat,
  output logic              shift_empty
);

  localparam int unsigned FRAME_W = DATA_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   left_q, left_d;
  smt_lvl_e           lvl_q, lvl_d;
  logic               bit_q, bit_d;
  logic               empty_q, empty_d;

  always_comb begin
    sh_d    = sh_q;
    left_d  = left_q;
    lvl_d   = lvl_q;
    bit_d   = bit_q;
    empty_d = empty_q;
    load    = 1'b0;
    if (rx_hold) begin
      // receive owns the line: drop the word, clock runs as receive clock
      empty_d = 1'b1;
      left_d  = '0;
      if (tick) lvl_d = (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
    end else if (tx_clear) begin
      empty_d = 1'b1;
      left_d  = '0;
      lvl_d   = LVL_LOW;
    end else if (tick) begin
      if (lvl_q == LVL_LOW) begin
        if (!empty_q && (left_q != '0)) begin
          lvl_d  = LVL_HIGH;
          bit_d  = sh_q[0];
          sh_d   = {1'b0, sh_q[FRAME_W-1:1]};
          left_d = left_q - 1'b1;
        end else if (empty_q && hold_full) begin
          load = 1'b1;
        end
      end else begin
        lvl_d = LVL_LOW;
        if (!empty_q && (left_q == '0)) begin
          if (hold_full) load = 1'b1;
          else           empty_d = 1'b1;
        end
      end
    end
    if (load) begin
      sh_d    = {bit9 & nine_mode, hold_word};
      left_d  = CNT_W'(smt_frame_bits(nine_mode, DATA_W));
      empty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      left_q  <= '0;
      lvl_q   <= LVL_LOW;
      bit_q   <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      sh_q    <= sh_d;
      left_q  <= left_d;
      lvl_q   <= lvl_d;
      bit_q   <= bit_d;
      empty_q <= empty_d;
    end
  end

  assign sclk        = (lvl_q == LVL_HIGH);
  assign sdat        = bit_q;
  assign shift_empty = empty_q;

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(tick)); // R7

  AST_RISE_CARRIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) && $past(!rx_hold && !tx_clear) |-> !$past(empty_q)); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clear && !rx_hold |=> shift_empty); // R8

endmodule

// File: rtl/sync_master_tx.sv
module sync_master_tx
  import smt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              master_en,
  input  logic              tx_en,
  input  logic              rx_cont_en,
  input  logic              rx_single_req,
  input  logic              rx_word_done,
  input  logic              nine_mode,
  input  logic              bit9,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_word,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              rx_single_busy,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              sdat_o,
  output logic              sdat_oe
);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_empty_q, hold_empty_d;
  logic              single_q, single_d;
  logic              rx_any, run, rx_hold, tx_clear;
  logic              tick, load, sclk_int, sdat_int, shift_empty_int;

  always_comb begin
    rx_any   = rx_cont_en | single_q;
    run      = port_en & (tx_en | rx_any);
    rx_hold  = port_en & rx_any;
    tx_clear = ~port_en | ~tx_en | ~master_en;

    hold_d       = hold_q;
    hold_empty_d = hold_empty_q;
    if (wr_stb) begin
      hold_d       = wr_word;
      hold_empty_d = 1'b0;
    end else if (load) begin
      hold_empty_d = 1'b1;
    end

    single_d = single_q;
    if (!port_en)                      single_d = 1'b0;
    else if (single_q && rx_word_done) single_d = 1'b0;
    else if (rx_single_req)            single_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q       <= '0;
      hold_empty_q <= 1'b1;
      single_q     <= 1'b0;
    end else begin
      hold_q       <= hold_d;
      hold_empty_q <= hold_empty_d;
      single_q     <= single_d;
    end
  end

  smt_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .divisor (divisor),
    .tick    (tick)
  );

  smt_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .rx_hold     (rx_hold),
    .tx_clear    (tx_clear),
    .hold_full   (~hold_empty_q),
    .hold_word   (hold_q),
    .nine_mode   (nine_mode),
    .bit9        (bit9),
    .load        (load),
    .sclk        (sclk_int),
    .sdat        (sdat_int),
    .shift_empty (shift_empty_int)
  );

  assign hold_empty     = hold_empty_q;
  assign shift_empty    = shift_empty_int;
  assign rx_single_busy = single_q;
  assign sclk_o         = sclk_int;
  assign sdat_o         = sdat_int;
  assign sclk_oe        = port_en & master_en & (tx_en | rx_any);
  assign sdat_oe        = port_en & master_en & tx_en & ~rx_any;

  AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !hold_empty_q); // R2

  AST_HOLD_SET_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty_q) |-> $past(load)); // R3

  AST_SINGLE_SELF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    single_q && rx_word_done |=> !single_q); // R10

endmodule

// File: tb/sync_master_tx_bench.sv
module sync_master_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       port_en, master_en, tx_en, rx_cont_en, rx_single_req, rx_word_done;
  logic       nine_mode, bit9, wr_stb;
  logic [7:0] divisor, wr_word;
  logic       hold_empty, shift_empty, rx_single_busy;
  logic       sclk_o, sclk_oe, sdat_o, sdat_oe;

  always #2.5 clk = ~clk;

  sync_master_tx u_sync_master_tx (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .master_en(master_en),
    .tx_en(tx_en), .rx_cont_en(rx_cont_en), .rx_single_req(rx_single_req),
    .rx_word_done(rx_word_done), .nine_mode(nine_mode), .bit9(bit9),
    .divisor(divisor), .wr_stb(wr_stb), .wr_word(wr_word),
    .hold_empty(hold_empty), .shift_empty(shift_empty),
    .rx_single_busy(rx_single_busy), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .sdat_o(sdat_o), .sdat_oe(sdat_oe)
  );

  int   checks = 0;
  int   fails  = 0;
  bit   finished = 0;
  int   cyc = 0;

  // monitor state (written only by the monitor)
  logic cap_q[$];
  logic exp_q[$];
  int   trans_cnt = 0, rise_cnt = 0, phase_err = 0, run_len = 0;
  logic prev_sclk = 0, prev_oe = 0, prev_se = 1;
  bit   seen_rise = 0;
  bit   mon_arm = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk = 0; prev_oe = 0; prev_se = 1; run_len = 0;
    end else begin
      if (!mon_arm) seen_rise = 0;
      if (sclk_o !== prev_sclk) begin
        trans_cnt++;
        if (prev_sclk) begin
          if (mon_arm && run_len != int'(divisor) + 1) phase_err++;
          if (prev_oe && !prev_se) cap_q.push_back(sdat_o);
        end else begin
          if (mon_arm && seen_rise && run_len != int'(divisor) + 1) phase_err++;
          seen_rise = mon_arm;
          rise_cnt++;
        end
        run_len = 1;
      end else begin
        run_len++;
      end
      prev_sclk = sclk_o; prev_oe = sdat_oe; prev_se = shift_empty;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog all requirements actual=%0d expected<%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_frame(input logic [7:0] w, input logic nine, input logic b9);
    for (int i = 0; i < 8; i++) exp_q.push_back(w[i]);
    if (nine) exp_q.push_back(b9);
  endtask

  task automatic write_word(input logic [7:0] w);
    wr_word = w; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_loaded();
    while (!hold_empty) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!(hold_empty && shift_empty)) @(negedge clk);
    cyc_wait(2 * (int'(divisor) + 1) + 4);
  endtask

  task automatic cmp_seg(input string req, input int cb, input int eb);
    int nc, ne, mism;
    nc = cap_q.size() - cb;
    ne = exp_q.size() - eb;
    mism = 0;
    chk(nc == ne, {req, " bit count"}, nc, ne);
    if (nc == ne)
      for (int i = 0; i < nc; i++) if (cap_q[cb+i] !== exp_q[eb+i]) mism++;
    chk(mism == 0, {req, " bit mismatches"}, mism, 0);
  endtask

  task automatic run_batch(input int nw, input logic nine, input logic [7:0] dv);
    int cb, eb, pe0;
    logic [7:0] w;
    logic b;
    divisor = dv; nine_mode = nine;
    cyc_wait(300);
    cb = cap_q.size(); eb = exp_q.size(); pe0 = phase_err;
    mon_arm = 1;
    for (int i = 0; i < nw; i++) begin
      wait_loaded();
      b = 1'($urandom % 2);
      w = 8'($urandom);
      bit9 = b;
      push_frame(w, nine, b);
      write_word(w);
      if (i == 0) begin
        chk(hold_empty == 1'b0, "R3 cleared by write", hold_empty, 0);
        wait_loaded();
        chk(shift_empty == 1'b0, "R4 busy after transfer", shift_empty, 0);
      end
    end
    wait_done();
    mon_arm = 0;
    cmp_seg("R5 R2 frames", cb, eb);
    chk(phase_err == pe0, "R7 R2 phase length", phase_err - pe0, 0);
    chk(shift_empty == 1'b1, "R4 empty after last word", shift_empty, 1);
  endtask

  initial begin
    int cb, eb, t0, r0, pe0;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; port_en = 0; master_en = 0; tx_en = 0; rx_cont_en = 0;
    rx_single_req = 0; rx_word_done = 0; nine_mode = 0; bit9 = 0;
    wr_stb = 0; wr_word = 0; divisor = 8'd3;
    cyc_wait(5);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
    chk(shift_empty == 1'b1, "R1 shift_empty", shift_empty, 1);
    chk(sclk_oe == 1'b0 && sdat_oe == 1'b0, "R1 enables", {sclk_oe, sdat_oe}, 0);
    chk(sclk_o == 1'b0, "R1 clock low", sclk_o, 0);

    // R6 / R7: write before enabling, divider held
    port_en = 1; master_en = 1;
    t0 = trans_cnt;
    write_word(8'hA5);
    cyc_wait(40);
    chk(hold_empty == 1'b0, "R3 write held", hold_empty, 0);
    chk(shift_empty == 1'b1, "R6 nothing shifted", shift_empty, 1);
    chk(trans_cnt == t0, "R7 divider held", trans_cnt - t0, 0);
    cb = cap_q.size(); eb = exp_q.size(); pe0 = phase_err;
    push_frame(8'hA5, 1'b0, 1'b0);
    mon_arm = 1;
    tx_en = 1;
    wait_done();
    mon_arm = 0;
    cmp_seg("R6 pre-written word", cb, eb);
    chk(phase_err == pe0, "R7 half period", phase_err - pe0, 0);
    t0 = trans_cnt;
    cyc_wait(60);
    chk(trans_cnt == t0, "R6 idle clock quiet", trans_cnt - t0, 0);

    // random back-to-back batches
    for (int b = 0; b < 5; b++)
      run_batch(5, 1'($urandom % 2), 8'($urandom % 5));

    // R11: ninth bit taken at transfer
    divisor = 8'd1; nine_mode = 1;
    cyc_wait(20);
    cb = cap_q.size(); eb = exp_q.size();
    bit9 = 1;
    write_word(8'h3C);
    push_frame(8'h3C, 1'b1, 1'b1);
    wait_loaded();
    bit9 = 0;
    write_word(8'hC3);
    @(negedge clk);
    bit9 = 1;
    push_frame(8'hC3, 1'b1, 1'b1);
    wait_loaded();
    bit9 = 0;
    wait_done();
    cmp_seg("R11 ninth bit sampling", cb, eb);
    nine_mode = 0;

    // R8: transmit disable aborts, held word kept
    divisor = 8'd2;
    cyc_wait(10);
    write_word(8'h5A);
    wait_loaded();
    write_word(8'h96);
    r0 = rise_cnt;
    while (rise_cnt < r0 + 3) @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    chk(sclk_oe == 1'b0 && sdat_oe == 1'b0, "R8 outputs released", {sclk_oe, sdat_oe}, 0);
    chk(shift_empty == 1'b1, "R8 word dropped", shift_empty, 1);
    chk(hold_empty == 1'b0, "R8 held word kept", hold_empty, 0);
    cyc_wait(10);
    cb = cap_q.size(); eb = exp_q.size();
    push_frame(8'h96, 1'b0, 1'b0);
    tx_en = 1;
    wait_done();
    cmp_seg("R8 resume with held word", cb, eb);

    // R9: continuous receive pre-empts
    write_word(8'h71);
    wait_loaded();
    write_word(8'hE8);
    r0 = rise_cnt;
    while (rise_cnt < r0 + 3) @(negedge clk);
    rx_cont_en = 1;
    @(negedge clk);
    chk(sdat_oe == 1'b0, "R9 data released", sdat_oe, 0);
    chk(sclk_oe == 1'b1, "R9 clock still driven", sclk_oe, 1);
    chk(hold_empty == 1'b0, "R9 held word kept", hold_empty, 0);
    t0 = trans_cnt;
    cyc_wait(30);
    chk(trans_cnt > t0, "R9 clock running", trans_cnt - t0, 1);
    cb = cap_q.size(); eb = exp_q.size();
    push_frame(8'hE8, 1'b0, 1'b0);
    rx_cont_en = 0;
    wait_done();
    cmp_seg("R9 resume after receive", cb, eb);

    // R10: single receive self-clears and transmission resumes
    divisor = 8'd1;
    cyc_wait(10);
    write_word(8'h0F);
    wait_loaded();
    write_word(8'hF0);
    r0 = rise_cnt;
    while (rise_cnt < r0 + 2) @(negedge clk);
    rx_single_req = 1;
    @(negedge clk);
    rx_single_req = 0;
    chk(rx_single_busy == 1'b1 && sdat_oe == 1'b0, "R10 single receive active",
        {rx_single_busy, sdat_oe}, 2);
    cyc_wait(20);
    chk(rx_single_busy == 1'b1, "R10 stays until done", rx_single_busy, 1);
    cb = cap_q.size(); eb = exp_q.size();
    push_frame(8'hF0, 1'b0, 1'b0);
    rx_word_done = 1;
    @(negedge clk);
    rx_word_done = 0;
    chk(rx_single_busy == 1'b0 && sdat_oe == 1'b1, "R10 self-clear and drive",
        {rx_single_busy, sdat_oe}, 1);
    wait_done();
    cmp_seg("R10 resumed word", cb, eb);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule